// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a simple request/acknowledge host port and an external 128K x 8 asynchronous static RAM. The host raises a request with a direction, an address and (for writes) a byte. The sequencer latches them, then runs the memory pins through a fixed series of phases. Each phase lasts a whole number of clock periods, derived from the memory's minimum times in nanoseconds and the clock period, so every pulse width, setup, hold, turnaround and cycle-time limit is met by construction. When the access completes, the block returns one acknowledge pulse, and for a read the captured byte.

The pins are an address bus, an active-low chip select, an active-high chip select, an active-low read (output) enable and an active-low write strobe. The data bus is split into an output value, an output enable for the pad tristate, and an input value. A separate standby request parks the memory deselected and holds off new host requests until it is withdrawn. An access already in flight always runs to completion first.

The state machine has seven states. IDLE waits for work. STANDBY parks the memory. RD_ACCESS selects the memory with the read enable low. RD_RELEASE deselects and keeps the bus undriven while the memory's outputs decay. WR_SETUP selects the memory with the data driven and the strobe high. WR_STROBE pulls the strobe low. WR_RECOVER raises the strobe, deselects, and keeps the data driven for one more phase.

The transitions are as follows. IDLE goes to STANDBY on a standby request. Otherwise IDLE goes to WR_SETUP or RD_ACCESS on a request, but not in the acknowledge cycle. STANDBY returns to IDLE when the standby request drops. Each timed state moves on when its phase timer expires: RD_ACCESS to RD_RELEASE to IDLE, and WR_SETUP to WR_STROBE to WR_RECOVER to IDLE.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and after reset, with no request, the pins are deselected: select_n=1, select=0, read_n=1, write_n=1, data-out enable=0, and acknowledge=0.
- R2: A read holds select_n=0, select=1, read_n=0, write_n=1 and data-out enable=0 for N_RD = max(ceil(70/T), ceil(35/T), ceil(70/T)) cycles. With T the clock period, the default N_RD is 7. The byte on the data input in the last of those cycles is what the host receives.
- R3: After a read, the sequencer deselects (the R1 levels) for N_HIZ = ceil(25/T) cycles (default 3) before acknowledging. The data-out enable never rises within N_HIZ cycles of the memory having been selected for a read.
- R4: A write first holds a setup phase of N_SETUP = max(1, ceil(60/T) - N_PULSE) cycles (default 1) with select active, read_n=1, write_n=1 and data-out enable=1. It then holds a strobe phase of N_PULSE = max(ceil(50/T), ceil(30/T)) cycles (default 5) with write_n=0. The written byte is stable on the bus for at least ceil(30/T) cycles before the strobe rises.
- R5: Chip select is active for at least ceil(60/T) cycles up to the end of the write strobe. The address does not change from the setup phase until after the strobe rises.
- R6: After the strobe rises, a recovery phase of N_REC = max(1, ceil(70/T) - N_SETUP - N_PULSE) cycles (default 1) deselects, keeps write_n=1 and still drives the same byte. Successive accesses begin no less than ceil(70/T) cycles apart.
- R7: The read enable is high throughout every write. The sequencer never drives the data bus while the read enable is low.
- R8: The acknowledge is high for exactly one cycle, in the first IDLE cycle after the access. A request seen in that cycle is not taken. A request held on is taken at the following clock edge.
- R9: While the standby input is high and the sequencer is idle, it enters standby. There it keeps the R1 pin levels, starts no access and gives no acknowledge. It takes a pending request one cycle after standby drops.
- R10: A standby request raised during an access does not cut it short. The access finishes with its normal phases and acknowledge, and standby is entered afterwards.
- R11: A read returns the byte last written to that address, or 0 for an address never written in the bench's memory.
- R12: The address, direction and write byte are latched when the request is taken. Changes on the host inputs during the access do not reach the memory pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, held until acknowledge |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W (17) | Byte address |
| host_wdata | input | DATA_W (8) | Byte to write |
| host_rdata | output | DATA_W (8) | Byte captured by the last read |
| host_ack | output | 1 | One-cycle completion pulse |
| sleep_req | input | 1 | Standby request |
| mem_addr | output | ADDR_W (17) | Memory address |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_rd_en_n | output | 1 | Active-low output enable of the memory |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_dq_o | output | DATA_W (8) | Data driven toward the memory |
| mem_dq_oe | output | 1 | Tristate enable for mem_dq_o |
| mem_dq_i | input | DATA_W (8) | Data seen on the memory bus |

## Verification
The hardest case to reach from the ports is a standby request that arrives in the middle of an access, while the host keeps a further request pending. The bench raises standby in a chosen phase of a write, then raises the next request. It checks that the write still completes and is acknowledged, that the memory then stays parked with no acknowledge, and that the pending request starts one cycle after standby drops. The bench's memory stub keeps driving the bus for the full decay window after every read and returns inverted data until the access window has elapsed. Because of this, an early capture or an early bus turnaround shows up as wrong read data or as contention.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STANDBY,
        ST_RD_ACCESS,
        ST_RD_RELEASE,
        ST_WR_SETUP,
        ST_WR_STROBE,
        ST_WR_RECOVER
    } seq_state_t;

    typedef struct packed {
        logic sel_n;
        logic sel;
        logic rd_en_n;
        logic wr_n;
        logic dq_oe;
    } pin_ctl_t;

    // whole clock periods covering a time in ns
    function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
        return (t_ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // loaded with length-1 on phase entry, counts down to zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode
    import sram_seq_pkg::*;
(
    input  seq_state_t state,
    output pin_ctl_t   pins
);

    always_comb begin
        pins = '{sel_n: 1'b1, sel: 1'b0, rd_en_n: 1'b1, wr_n: 1'b1, dq_oe: 1'b0};
        unique case (state)
            ST_IDLE, ST_STANDBY, ST_RD_RELEASE: begin
                pins = '{sel_n: 1'b1, sel: 1'b0, rd_en_n: 1'b1, wr_n: 1'b1, dq_oe: 1'b0};
            end
            ST_RD_ACCESS: begin
                pins = '{sel_n: 1'b0, sel: 1'b1, rd_en_n: 1'b0, wr_n: 1'b1, dq_oe: 1'b0};
            end
            ST_WR_SETUP: begin
                pins = '{sel_n: 1'b0, sel: 1'b1, rd_en_n: 1'b1, wr_n: 1'b1, dq_oe: 1'b1};
            end
            ST_WR_STROBE: begin
                pins = '{sel_n: 1'b0, sel: 1'b1, rd_en_n: 1'b1, wr_n: 1'b0, dq_oe: 1'b1};
            end
            ST_WR_RECOVER: begin
                pins = '{sel_n: 1'b1, sel: 1'b0, rd_en_n: 1'b1, wr_n: 1'b1, dq_oe: 1'b1};
            end
            default: begin
                pins = '{sel_n: 1'b1, sel: 1'b0, rd_en_n: 1'b1, wr_n: 1'b1, dq_oe: 1'b0};
            end
        endcase
    end

endmodule

// File: rtl/sram_hold_regs.sv
module sram_hold_regs #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (latch) begin
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= bus_in;
        end
    end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 10,
    parameter int T_CYC_NS  = 70,
    parameter int T_ACC_NS  = 70,
    parameter int T_OE_NS   = 35,
    parameter int T_HIZ_NS  = 25,
    parameter int T_WP_NS   = 50,
    parameter int T_CW_NS   = 60,
    parameter int T_DS_NS   = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_ack,
    input  logic              sleep_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_rd_en_n,
    output logic              mem_wr_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    // phase lengths in clock cycles
    localparam int N_CYC   = ns_to_cycles(T_CYC_NS, CLK_NS);
    localparam int N_RD    = imax(imax(ns_to_cycles(T_ACC_NS, CLK_NS),
                                       ns_to_cycles(T_OE_NS, CLK_NS)), N_CYC);
    localparam int N_HIZ   = imax(1, ns_to_cycles(T_HIZ_NS, CLK_NS));
    localparam int N_PULSE = imax(1, imax(ns_to_cycles(T_WP_NS, CLK_NS),
                                          ns_to_cycles(T_DS_NS, CLK_NS)));
    localparam int N_CW    = ns_to_cycles(T_CW_NS, CLK_NS);
    localparam int N_SETUP = imax(1, N_CW - N_PULSE);
    localparam int N_REC   = imax(1, N_CYC - N_SETUP - N_PULSE);
    localparam int N_MAX   = imax(imax(N_RD, N_HIZ), imax(imax(N_PULSE, N_SETUP), N_REC));
    localparam int CNT_W   = imax(1, $clog2(N_MAX + 1));

    localparam logic [CNT_W-1:0] L_RD    = CNT_W'(N_RD - 1);
    localparam logic [CNT_W-1:0] L_HIZ   = CNT_W'(N_HIZ - 1);
    localparam logic [CNT_W-1:0] L_SETUP = CNT_W'(N_SETUP - 1);
    localparam logic [CNT_W-1:0] L_PULSE = CNT_W'(N_PULSE - 1);
    localparam logic [CNT_W-1:0] L_REC   = CNT_W'(N_REC - 1);

    seq_state_t       state_q, state_d;
    logic             ack_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             accept;
    logic             capture;
    logic             finish;
    pin_ctl_t         pins;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ack_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ack_q   <= finish;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        finish   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (sleep_req) begin
                    state_d = ST_STANDBY;
                end else if (host_req && !ack_q) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (host_we) begin
                        state_d = ST_WR_SETUP;
                        tmr_val = L_SETUP;
                    end else begin
                        state_d = ST_RD_ACCESS;
                        tmr_val = L_RD;
                    end
                end
            end
            ST_STANDBY: begin
                if (!sleep_req) begin
                    state_d = ST_IDLE;
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_expired) begin
                    capture  = 1'b1;
                    state_d  = ST_RD_RELEASE;
                    tmr_load = 1'b1;
                    tmr_val  = L_HIZ;
                end
            end
            ST_RD_RELEASE: begin
                if (tmr_expired) begin
                    finish  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_WR_SETUP: begin
                if (tmr_expired) begin
                    state_d  = ST_WR_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = L_PULSE;
                end
            end
            ST_WR_STROBE: begin
                if (tmr_expired) begin
                    state_d  = ST_WR_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = L_REC;
                end
            end
            ST_WR_RECOVER: begin
                if (tmr_expired) begin
                    finish  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_hold_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .latch      (accept),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .capture    (capture),
        .bus_in     (mem_dq_i),
        .addr_q     (mem_addr),
        .wdata_q    (mem_dq_o),
        .rdata_q    (host_rdata)
    );

    // ---------------- outputs ----------------
    sram_pin_decode u_decode (
        .state (state_q),
        .pins  (pins)
    );

    assign mem_sel_n   = pins.sel_n;
    assign mem_sel     = pins.sel;
    assign mem_rd_en_n = pins.rd_en_n;
    assign mem_wr_n    = pins.wr_n;
    assign mem_dq_oe   = pins.dq_oe;
    assign host_ack    = ack_q;

    // ---------------- assertions ----------------
    localparam logic [CNT_W-1:0] C_HIZ   = CNT_W'(N_HIZ);
    localparam logic [CNT_W-1:0] C_PULSE = CNT_W'(N_PULSE);

    logic [CNT_W-1:0] rel_cnt;   // cycles since memory last allowed to drive
    logic [CNT_W-1:0] low_cnt;   // cycles the strobe has been low

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rel_cnt <= C_HIZ;
        end else if (!mem_sel_n && !mem_rd_en_n) begin
            rel_cnt <= '0;
        end else if (rel_cnt < C_HIZ) begin
            rel_cnt <= rel_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (mem_wr_n) begin
            low_cnt <= '0;
        end else if (low_cnt < C_PULSE) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (mem_sel_n && !mem_sel && mem_rd_en_n && mem_wr_n && !mem_dq_oe));

    p_standby_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STANDBY) |-> (mem_sel_n && !mem_sel && !mem_dq_oe && !host_ack));

    p_no_fight_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_en_n |-> !mem_dq_oe);

    p_write_oe_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> (mem_rd_en_n && mem_dq_oe));

    p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mem_wr_n) |-> $stable(mem_addr));

    p_strobe_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> (low_cnt >= C_PULSE));

    p_turnaround_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (rel_cnt >= C_HIZ));

endmodule

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;

    localparam int CLK_PERIOD_NS = 10;

    function automatic int cdiv(input int t_ns);
        return (t_ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // expected phase lengths, from the requirements
    localparam int E_CYC  = cdiv(70);
    localparam int E_VAL  = mx(cdiv(70), cdiv(35));
    localparam int E_RD   = mx(E_VAL, E_CYC);
    localparam int E_HIZ  = cdiv(25);
    localparam int E_WP   = cdiv(50);
    localparam int E_DS   = cdiv(30);
    localparam int E_PUL  = mx(E_WP, E_DS);
    localparam int E_CW   = cdiv(60);
    localparam int E_SET  = mx(1, E_CW - E_PUL);
    localparam int E_REC  = mx(1, E_CYC - E_SET - E_PUL);

    // {sel_n, sel, rd_en_n, wr_n, dq_oe}
    localparam logic [4:0] P_IDLE = 5'b10110;
    localparam logic [4:0] P_RD   = 5'b01010;
    localparam logic [4:0] P_SET  = 5'b01111;
    localparam logic [4:0] P_STB  = 5'b01101;
    localparam logic [4:0] P_REC  = 5'b10111;

    logic        clk, rst_n;
    logic        host_req, host_we, host_ack, sleep_req;
    logic [16:0] host_addr, mem_addr;
    logic [7:0]  host_wdata, host_rdata, mem_dq_o, mem_dq_i;
    logic        mem_sel_n, mem_sel, mem_rd_en_n, mem_wr_n, mem_dq_oe;
    logic [4:0]  pins;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    sram_async_ctrl #(.CLK_NS(CLK_PERIOD_NS)) u_sram_async_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_req    (host_req),
        .host_we     (host_we),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .host_ack    (host_ack),
        .sleep_req   (sleep_req),
        .mem_addr    (mem_addr),
        .mem_sel_n   (mem_sel_n),
        .mem_sel     (mem_sel),
        .mem_rd_en_n (mem_rd_en_n),
        .mem_wr_n    (mem_wr_n),
        .mem_dq_o    (mem_dq_o),
        .mem_dq_oe   (mem_dq_oe),
        .mem_dq_i    (mem_dq_i)
    );

    assign pins = {mem_sel_n, mem_sel, mem_rd_en_n, mem_wr_n, mem_dq_oe};

    initial clk = 1'b0;
    always #(CLK_PERIOD_NS / 2) clk = ~clk;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // ---------------- memory stub ----------------
    logic [7:0] stub_mem [int];
    logic [7:0] ref_mem  [int];
    logic       stub_drv;
    logic [7:0] stub_data;
    int  rd_cyc = 0, hold = 0, cw = 0, ds = 0, wp = 0, cw_at = 0, ds_at = 0;
    int  cyc = 0, last_start = -1000;
    bit  prev_sel = 0;
    logic [7:0]  last_d, w_data;
    logic [16:0] w_addr;

    initial begin
        stub_drv  = 1'b0;
        stub_data = 8'h00;
        last_d    = 8'h00;
        w_data    = 8'h00;
        w_addr    = '0;
    end

    assign mem_dq_i = mem_dq_oe ? mem_dq_o : (stub_drv ? stub_data : 8'h5A);

    always @(negedge clk) begin
        logic       sel_on, rd, drv;
        logic [7:0] val;
        if (rst_n) begin
            sel_on = !mem_sel_n && mem_sel;
            rd     = sel_on && !mem_rd_en_n && mem_wr_n;
            if (sel_on && !prev_sel) begin
                chk(cyc - last_start >= E_CYC, "R6", "access spacing",
                    32'(cyc - last_start), 32'(E_CYC));
                last_start = cyc;
            end
            prev_sel = sel_on;
            // read side: wrong data until the access window has elapsed
            drv = 1'b0;
            if (rd) begin
                rd_cyc++;
                hold = E_HIZ;
                val = stub_mem.exists(int'(mem_addr)) ? stub_mem[int'(mem_addr)] : 8'h00;
                stub_data <= (rd_cyc >= E_VAL) ? val : ~val;
                drv = 1'b1;
            end else begin
                rd_cyc = 0;
                if (hold > 0) begin
                    hold--;
                    drv = 1'b1;
                end
            end
            stub_drv <= drv;
            if (mem_dq_oe)
                chk(!drv, "R3", "bus contention", 32'(drv), 32'd0);
            // write side
            cw = sel_on ? cw + 1 : 0;
            ds = mem_dq_oe ? ((mem_dq_o == last_d && ds > 0) ? ds + 1 : 1) : 0;
            last_d = mem_dq_o;
            if (sel_on && !mem_wr_n) begin
                if (wp == 0) w_addr = mem_addr;
                else chk(mem_addr == w_addr, "R5", "address moved under strobe",
                         32'(mem_addr), 32'(w_addr));
                wp++;
                cw_at  = cw;
                ds_at  = ds;
                w_data = mem_dq_o;
            end else if (wp > 0) begin
                chk(wp >= E_WP, "R4", "strobe width", 32'(wp), 32'(E_WP));
                chk(ds_at >= E_DS, "R4", "data setup", 32'(ds_at), 32'(E_DS));
                chk(cw_at >= E_CW, "R5", "select before write end", 32'(cw_at), 32'(E_CW));
                chk(mem_dq_oe && mem_dq_o == w_data, "R6", "data hold after strobe",
                    32'(mem_dq_o), 32'(w_data));
                stub_mem[int'(w_addr)] = w_data;
                wp = 0;
            end
            cyc++;
        end
    end

    // ---------------- reference sequence ----------------
    task automatic idle_cycle(input string rq);
        @(negedge clk);
        chk(pins == P_IDLE, rq, "deselected pins", 32'(pins), 32'(P_IDLE));
        chk(host_ack == 1'b0, rq, "no ack", 32'(host_ack), 32'd0);
    endtask

    task automatic run_access(input bit we, input logic [16:0] a, input logic [7:0] d,
                              input int lead, input int sleep_k, input string rq);
        logic [4:0] seq[$];
        logic [7:0] exp_rd;
        host_req   = 1'b1;
        host_we    = we;
        host_addr  = a;
        host_wdata = d;
        for (int i = 0; i < lead; i++) idle_cycle({rq, " R8"});
        if (we) begin
            for (int i = 0; i < E_SET; i++) seq.push_back(P_SET);
            for (int i = 0; i < E_PUL; i++) seq.push_back(P_STB);
            for (int i = 0; i < E_REC; i++) seq.push_back(P_REC);
        end else begin
            for (int i = 0; i < E_RD; i++)  seq.push_back(P_RD);
            for (int i = 0; i < E_HIZ; i++) seq.push_back(P_IDLE);
        end
        for (int k = 0; k < seq.size(); k++) begin
            @(negedge clk);
            chk(pins == seq[k], rq, $sformatf("phase pins k=%0d", k), 32'(pins), 32'(seq[k]));
            chk(host_ack == 1'b0, rq, "ack early", 32'(host_ack), 32'd0);
            if (!mem_sel_n)
                chk(mem_addr == a, "R12", "latched address", 32'(mem_addr), 32'(a));
            if (mem_dq_oe)
                chk(mem_dq_o == d, "R12", "latched data", 32'(mem_dq_o), 32'(d));
            if (k == 0) begin
                host_addr  = ~a;
                host_wdata = ~d;
                host_we    = ~we;
            end
            if (k == sleep_k) sleep_req = 1'b1;
        end
        @(negedge clk);
        chk(host_ack == 1'b1, "R8", "ack after access", 32'(host_ack), 32'd1);
        chk(pins == P_IDLE, "R1", "pins in ack cycle", 32'(pins), 32'(P_IDLE));
        if (we) begin
            ref_mem[int'(a)] = d;
        end else begin
            exp_rd = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
            chk(host_rdata == exp_rd, "R11", "read data (R2 capture)",
                32'(host_rdata), 32'(exp_rd));
        end
        host_req = 1'b0;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        rst_n      = 1'b0;
        host_req   = 1'b0;
        host_we    = 1'b0;
        host_addr  = '0;
        host_wdata = '0;
        sleep_req  = 1'b0;
        repeat (3) @(negedge clk);
        chk(pins == P_IDLE, "R1", "pins in reset", 32'(pins), 32'(P_IDLE));
        chk(host_ack == 1'b0, "R1", "ack in reset", 32'(host_ack), 32'd0);
        rst_n = 1'b1;
        idle_cycle("R1");
        idle_cycle("R1");

        // basic write then back-to-back read (R4 R5 R6 R2 R3 R8)
        run_access(1'b1, 17'h00010, 8'hA5, 0, -1, "R4");
        run_access(1'b0, 17'h00010, 8'h00, 1, -1, "R2");
        idle_cycle("R3");
        // address extremes and an unwritten location (R11)
        run_access(1'b1, 17'h1FFFF, 8'h3C, 0, -1, "R4");
        run_access(1'b1, 17'h00000, 8'hC3, 1, -1, "R4");
        run_access(1'b0, 17'h1FFFF, 8'h00, 1, -1, "R2");
        run_access(1'b0, 17'h00000, 8'h00, 1, -1, "R2");
        run_access(1'b0, 17'h0ABCD, 8'h00, 1, -1, "R11");

        // standby from idle holds off a request (R9)
        @(negedge clk);
        sleep_req = 1'b1;
        idle_cycle("R9");
        host_req  = 1'b1;
        host_we   = 1'b0;
        host_addr = 17'h00010;
        for (int i = 0; i < 12; i++) idle_cycle("R9");
        sleep_req = 1'b0;
        run_access(1'b0, 17'h00010, 8'h00, 1, -1, "R9");

        // standby raised mid-write: write completes, then parks (R10)
        @(negedge clk);
        run_access(1'b1, 17'h00123, 8'h77, 0, 2, "R10");
        host_req  = 1'b1;
        host_we   = 1'b0;
        host_addr = 17'h00123;
        for (int i = 0; i < 6; i++) idle_cycle("R10");
        sleep_req = 1'b0;
        run_access(1'b0, 17'h00123, 8'h00, 1, -1, "R10");

        // standby raised mid-read (R10)
        run_access(1'b0, 17'h1FFFF, 8'h00, 1, 4, "R10");
        for (int i = 0; i < 3; i++) idle_cycle("R10");
        sleep_req = 1'b0;
        @(negedge clk);

        // mixed patterns (R11)
        for (int i = 0; i < 6; i++)
            run_access(1'b1, 17'(i * 17'h05A5B + 3), 8'(i * 37 + 9), (i == 0) ? 0 : 1, -1, "R11");
        for (int i = 5; i >= 0; i--)
            run_access(1'b0, 17'(i * 17'h05A5B + 3), 8'h00, 1, -1, "R11");
        run_access(1'b1, 17'h00010, 8'hFF, 1, -1, "R11");
        run_access(1'b0, 17'h00010, 8'h00, 1, -1, "R11");
        idle_cycle("R1");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD_NS * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog timeout actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule